// File: doc/BRIEF.md
# General-Purpose I/O Port with Latch-Based Input Synchronizer

An 8-bit bidirectional I/O port for a small microcontroller. Software reaches three registers over a single-cycle register bus: a direction register, an output data register and a read-only pin-value register. Each direction bit selects per pin whether the pad is driven with the matching output bit or left floating. The port reports the drive value and the enable as separate outputs, so the chip's pad ring builds the tri-state buffer.

The pin-value register always shows the sampled pad level, whether a pin is an input or a driven output. Every pad bit passes through a two-stage synchronizer. The first stage is a capture stage that behaves like a latch that is open while the clock is high and closed while it is low. The second stage is a rising-edge register. As a result, an asynchronous pad transition becomes visible between half a clock period and one and a half clock periods after it happens. A value that software writes to a driven pin can be read back exactly one clock period after the write.

Top module: `gpio_sync_port`

## Requirements
- R1: After reset the direction, output and pin-value registers all read 0, pad_oe_o is 0 and pad_o is 0.
- R2: The direction register sits at address 1. A write there updates it at the rising edge that samples we_i. A read returns its value combinationally in the same cycle as the address.
- R3: The output data register sits at address 2. It is written and read the same way as the direction register.
- R4: For each bit, pad_oe_o equals the direction bit (1 = driven, 0 = high impedance) and pad_o equals the output data bit.
- R5: The pin-value register at address 0 is read-only. A write to address 0 changes neither the pin-value register nor the direction or output registers.
- R6: A pad change that arrives while the clock is high is read at address 0 starting from the next rising edge. Its latency therefore lies between half a period and one period.
- R7: A pad change that arrives while the clock is low is not captured until the following falling edge. It appears at the rising edge after that, which gives a latency of up to one and a half periods.
- R8: After a write to the output register of a driven pin, address 0 still returns the old value in the cycle right after the write. The new value appears one clock period later.
- R9: For every bit, the pin-value register reflects the pad level, whether the bit is an input or a driven output.
- R10: Address 3 reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| we_i | input | 1 | Write enable, sampled on the rising edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, same cycle |
| pad_i | input | 8 | Sampled pad level |
| pad_o | output | 8 | Value driven onto the pads |
| pad_oe_o | output | 8 | Per-pin drive enable |

## Verification
The hardest cases to reach are the two ends of the latency window. Both depend on where a pad edge falls within the clock period, which register-level stimulus never controls. The bench therefore moves its external pad value at fixed offsets after a rising edge: early in the high phase, just before the falling edge, and just after it. It then reads address 0 on both sides of the rising edge where the change should first appear. The readback case uses a bench pad model that mirrors pad_o wherever pad_oe_o is set. A read placed in the cycle straight after a write then shows the one-cycle delay of the stale value.

// File: rtl/gpio_sync_pkg.sv
package gpio_sync_pkg;
  localparam int unsigned ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_PIN  = 2'd0,
    REG_DIR  = 2'd1,
    REG_OUT  = 2'd2,
    REG_RSVD = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync_cell.sv
// One bit of synchronizer. The capture stage closes on the falling edge and
// holds through the low phase, which is what the next rising-edge stage of a
// high-transparent latch sees; a falling-edge register gives that behaviour
// without a race at the rising edge.
module gpio_sync_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic capt_q;
  logic pin_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) capt_q <= 1'b0;
    else         capt_q <= d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= capt_q;
  end

  assign q_o = pin_q;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_sync_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  rdata_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  out_o
);
  gpio_reg_e    sel;
  logic [WIDTH-1:0] dir_q, out_q;

  assign sel = gpio_reg_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (we_i) begin
      if (sel == REG_DIR) dir_q <= wdata_i;
      if (sel == REG_OUT) out_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (sel)
      REG_PIN: rdata_o = pin_i;
      REG_DIR: rdata_o = dir_q;
      REG_OUT: rdata_o = out_q;
      default: rdata_o = '0;
    endcase
  end

  assign dir_o = dir_q;
  assign out_o = out_q;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] out_i,
  output logic [WIDTH-1:0] pad_o,
  output logic [WIDTH-1:0] pad_oe_o
);
  assign pad_o    = out_i;
  assign pad_oe_o = dir_i;
endmodule

// File: rtl/gpio_sync_port.sv
module gpio_sync_port
  import gpio_sync_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pad_i,
  output logic [WIDTH-1:0]  pad_o,
  output logic [WIDTH-1:0]  pad_oe_o
);
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] dir;
  logic [WIDTH-1:0] outv;

  for (genvar b = 0; b < WIDTH; b++) begin : g_sync
    gpio_sync_cell i_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pad_i[b]),
      .q_o   (pin_sync[b])
    );
  end

  gpio_regfile #(.WIDTH(WIDTH)) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .we_i   (we_i),
    .wdata_i(wdata_i),
    .pin_i  (pin_sync),
    .rdata_o(rdata_o),
    .dir_o  (dir),
    .out_o  (outv)
  );

  gpio_pad_ctrl #(.WIDTH(WIDTH)) i_pad (
    .dir_i   (dir),
    .out_i   (outv),
    .pad_o   (pad_o),
    .pad_oe_o(pad_oe_o)
  );
endmodule

// File: rtl/gpio_sync_port_chk.sv
module gpio_sync_port_chk
  import gpio_sync_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [WIDTH-1:0]  wdata_i,
  input logic [WIDTH-1:0]  rdata_o,
  input logic [WIDTH-1:0]  pad_i,
  input logic [WIDTH-1:0]  pad_o,
  input logic [WIDTH-1:0]  pad_oe_o
);
  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd1) |=> (pad_oe_o == $past(wdata_i))); // R2
  AST_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == 2'd1) |=> $stable(pad_oe_o)); // R5
  AST_OUT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd2) |=> (pad_o == $past(wdata_i))); // R3
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == 2'd2) |=> $stable(pad_o)); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd3) |-> (rdata_o == '0)); // R10
  AST_PIN_TRACKS_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(pad_i) && $past($stable(pad_i)) && addr_i == 2'd0) |-> (rdata_o == pad_i)); // R9
endmodule

bind gpio_sync_port gpio_sync_port_chk #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_gpio_sync_port.sv
module test_gpio_sync_port;
  localparam int W = 8;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic         we = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata, pad_in, pad_out, pad_oe;
  logic [W-1:0] ext = '0;
  int n_tests = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  // pad model: driven pins follow pad_o, others follow the external level
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_sync_port #(.WIDTH(W)) i_gpio_sync_port (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad_in),
    .pad_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // read at current time, combinational
  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  // write, leaves time at effective edge + 2
  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(posedge clk); #2;
    addr = a; we = 1'b1; wdata = d;
    @(posedge clk); #2;
    we = 1'b0;
  endtask

  task automatic t_reset();
    logic [W-1:0] d;
    rd(2'd0, d); check("R1", "pin after reset", d, 8'h00);
    rd(2'd1, d); check("R1", "dir after reset", d, 8'h00);
    rd(2'd2, d); check("R1", "out after reset", d, 8'h00);
    check("R1", "pad_oe after reset", pad_oe, 8'h00);
    check("R1", "pad_o after reset", pad_out, 8'h00);
  endtask

  task automatic t_regs();
    logic [W-1:0] d;
    wr(2'd1, 8'h3C);
    rd(2'd1, d); check("R2", "dir readback", d, 8'h3C);
    check("R4", "pad_oe follows dir", pad_oe, 8'h3C);
    wr(2'd2, 8'hA6);
    rd(2'd2, d); check("R3", "out readback", d, 8'hA6);
    check("R4", "pad_o follows out", pad_out, 8'hA6);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_readonly();
    logic [W-1:0] d;
    ext = 8'h5A;
    repeat (3) @(posedge clk);
    wr(2'd0, 8'hFF);
    repeat (2) @(posedge clk); #2;
    rd(2'd0, d); check("R5", "pin ignores write", d, 8'h5A);
    rd(2'd1, d); check("R5", "dir after pin write", d, 8'h00);
    rd(2'd2, d); check("R5", "out after pin write", d, 8'h00);
    wr(2'd3, 8'hC3);
    rd(2'd3, d); check("R10", "unused addr reads 0", d, 8'h00);
    rd(2'd1, d); check("R10", "dir after addr3 write", d, 8'h00);
    rd(2'd2, d); check("R10", "out after addr3 write", d, 8'h00);
    ext = 8'h00;
    repeat (3) @(posedge clk);
  endtask

  // pad changes dly ns after a rising edge (high phase is 0..10)
  task automatic t_ext_phase(input int dly, input logic [W-1:0] v,
                             input logic late, input string req);
    logic [W-1:0] old, d;
    @(posedge clk); #2; rd(2'd0, old);
    @(posedge clk); #(dly); ext = v;
    @(posedge clk); #2; rd(2'd0, d);
    if (late) begin
      check(req, "old value one period after low-phase change", d, old);
      @(posedge clk); #2; rd(2'd0, d);
      check(req, "new value after 1.5 periods", d, v);
    end else begin
      check(req, "new value at next rising edge", d, v);
    end
  endtask

  task automatic t_readback();
    logic [W-1:0] d;
    ext = 8'h00;
    wr(2'd1, 8'hFF);
    repeat (2) @(posedge clk); #2;
    rd(2'd0, d); check("R8", "driven pins low", d, 8'h00);
    wr(2'd2, 8'hFF);
    rd(2'd0, d); check("R8", "stale read right after write", d, 8'h00);
    @(posedge clk); #2;
    rd(2'd0, d); check("R8", "new value one period later", d, 8'hFF);
  endtask

  task automatic t_mixed();
    logic [W-1:0] d;
    wr(2'd1, 8'h0F);
    wr(2'd2, 8'h05);
    ext = 8'hA3;
    repeat (3) @(posedge clk); #2;
    rd(2'd0, d); check("R9", "mixed in/out pin value", d, 8'hA5);
    check("R4", "pad_oe mixed", pad_oe, 8'h0F);
  endtask

  initial begin
    #45 rst_n = 1'b1;
    #1 t_reset();
    t_regs();
    t_readonly();
    t_ext_phase(2, 8'h81, 1'b0, "R6");
    t_ext_phase(9, 8'h7E, 1'b0, "R6");
    t_ext_phase(11, 8'h18, 1'b1, "R7");
    t_ext_phase(19, 8'hE7, 1'b1, "R7");
    t_readback();
    t_mixed();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule